// File: doc/BRIEF.md
# Emulator Instruction Dispatch Decoder

This block sits beside a microcoded sequencer that runs a 16-bit minicomputer instruction set. It holds the 16-bit instruction register and, for each microinstruction, forms a 4-bit modifier. The sequencer ORs that modifier into its next-address field, which is how the microcode branches on the opcode. Bit 15 is the most significant bit everywhere in this block.

A 3-bit function code selects the dispatch for the current microinstruction. Five kinds of dispatch are available:

- loading the instruction register, which also gives a first-level dispatch;
- a 16-way priority dispatch on the instruction fields;
- a dispatch on the lowest bus bit;
- a source-accumulator dispatch through a 128-entry parameter table;
- accumulator addressing, in which the two low bits of the register-select field are replaced by a complemented accumulator field of the instruction.

The block also keeps the single-bit skip flag. An external source sets the flag, and an instruction load clears it.

Top module: `dispatch_decoder`

## Requirements
- R1: With function code 1 (load), the instruction register takes `busIn` at the clock edge. `irOut` shows the new value from the next cycle onward. With any other code, the register keeps its value.
- R2: With function code 1, `nextMod` in that same cycle is {busIn[15], busIn[10:8]}.
- R3: `skipSet` high sets `skipOut` at the next edge. A load (code 1) clears it at the next edge, and the clear wins when both fall in one cycle.
- R4: With function code 2 (priority dispatch), `nextMod` is chosen as follows. If IR[15] is 1, it is 3 minus IR[7:6]. Otherwise IR[14:13] decides: 0 gives IR[12:11], 1 gives 4, and 2 gives 5.
- R5: With function code 2, IR[15]=0 and IR[14:13]=3, `nextMod` depends on the opcode nibble IR[11:8]. The nibble 0 maps to 1, 1 maps to 0, 6 maps to 14 and 14 maps to 6. Every other nibble passes through unchanged.
- R6: With function code 3 (odd-bus dispatch), `nextMod` is {3'b000, busIn[0]}.
- R7: With function code 4 (source accumulator), `nextMod` is 3 minus IR[7:6] when IR[15] is 1. Otherwise it is entry IR[14:8] of `AC_TABLE`, where entry i sits in bits [4i+3:4i].
- R8: Code 4 sets `rSelOut[1:0]` to IR[14:13] XOR 3. Codes 5 (destination accumulator) and 6 (novel-shift) set it to IR[12:11] XOR 3. `rSelOut[4:2]` always equals `rSelIn[4:2]`, and for every other code `rSelOut` equals `rSelIn`.
- R9: With function codes 0, 5, 6 or 7, `nextMod` is zero.
- R10: After reset `irOut` is 0 and `skipOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fnCode | input | 3 | Dispatch function of the current microinstruction |
| busIn | input | 16 | Processor bus |
| rSelIn | input | 5 | Register-select field from the microinstruction |
| skipSet | input | 1 | Sets the skip flag |
| nextMod | output | 4 | Modifier ORed into the next address |
| rSelOut | output | 5 | Register select after accumulator substitution |
| irOut | output | 16 | Instruction register |
| skipOut | output | 1 | Skip flag |

## Verification
Two things can land in the same cycle: an instruction load and an external skip set. The bench raises `skipSet` in the very cycle of a load and then requires `skipOut` to read 0, so the clear must take priority. A second case pairs a load with the modifier output. In the load cycle `nextMod` must follow the bus while `irOut` still shows the old instruction, and the new instruction must be visible one cycle later.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [2:0] {
    FN_NONE   = 3'd0,
    FN_LOADIR = 3'd1,
    FN_IDISP  = 3'd2,
    FN_BUSODD = 3'd3,
    FN_ACSRC  = 3'd4,
    FN_ACDST  = 3'd5,
    FN_DNS    = 3'd6,
    FN_SPARE  = 3'd7
  } dispFn_e;

  typedef struct packed {
    logic loadIr;
    logic idisp;
    logic busOdd;
    logic acSrc;
    logic acDst;
  } dispStrb_t;

  localparam int DEF_TBL_ENTRIES = 128;
  localparam int DEF_MOD_W       = 4;

  // Placeholder table contents; real contents are supplied by the integrator.
  function automatic logic [DEF_TBL_ENTRIES*DEF_MOD_W-1:0] defaultAcTable();
    logic [DEF_TBL_ENTRIES*DEF_MOD_W-1:0] t;
    for (int i = 0; i < DEF_TBL_ENTRIES; i++) begin
      t[i*DEF_MOD_W +: DEF_MOD_W] = DEF_MOD_W'((i * 5 + 3) & 15);
    end
    return t;
  endfunction

endpackage

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [2:0] fnCode,
  output dispStrb_t strb
);

  dispFn_e fn;
  assign fn = dispFn_e'(fnCode);

  always_comb begin
    strb = '0;
    unique case (fn)
      FN_LOADIR: strb.loadIr = 1'b1;
      FN_IDISP:  strb.idisp  = 1'b1;
      FN_BUSODD: strb.busOdd = 1'b1;
      FN_ACSRC:  strb.acSrc  = 1'b1;
      FN_ACDST,
      FN_DNS:    strb.acDst  = 1'b1;
      default:   strb = '0;
    endcase
  end

  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R9

  AST_IDLE_NO_STRB: assert property (@(posedge clk) disable iff (!rstN)
    (fnCode == 3'd0 || fnCode == 3'd7) |-> (strb == '0)); // R9

endmodule

// File: rtl/disp_datapath.sv
module disp_datapath
  import disp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MOD_W     = 4,
  parameter int RSEL_W    = 5,
  parameter int TBL_IDX_W = 7,
  localparam int TBL_ENTRIES = 1 << TBL_IDX_W,
  parameter logic [TBL_ENTRIES*MOD_W-1:0] AC_TABLE = defaultAcTable()
)(
  input  logic              clk,
  input  logic              rstN,
  input  dispStrb_t         strb,
  input  logic [DATA_W-1:0] busIn,
  input  logic [RSEL_W-1:0] rSelIn,
  input  logic              skipSet,
  output logic [MOD_W-1:0]  nextMod,
  output logic [RSEL_W-1:0] rSelOut,
  output logic [DATA_W-1:0] irOut,
  output logic              skipOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0]    irQ;
  logic                 skipQ;
  logic [MOD_W-1:0]     loadMod, idispMod, acSrcMod, shComplMod, tblMod;
  logic [TBL_IDX_W-1:0] tblIdx;
  logic [1:0]           srcAc, dstAc;

  // Instruction register and skip flag; a load's clear beats an external set.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irQ   <= '0;
      skipQ <= 1'b0;
    end else begin
      if (strb.loadIr) irQ <= busIn;
      if (strb.loadIr)  skipQ <= 1'b0;
      else if (skipSet) skipQ <= 1'b1;
    end
  end

  assign irOut   = irQ;
  assign skipOut = skipQ;

  // First-level dispatch straight from the bus.
  assign loadMod = {busIn[MSB], busIn[MSB-5:MSB-7]};

  // Complemented shift field shared by two dispatches.
  assign shComplMod = MOD_W'(2'd3 - irQ[MSB-8:MSB-9]);

  // Source-accumulator table lookup.
  assign tblIdx = irQ[MSB-1:MSB-TBL_IDX_W];
  assign tblMod = AC_TABLE[int'(tblIdx)*MOD_W +: MOD_W];

  always_comb begin
    if (irQ[MSB]) begin
      idispMod = shComplMod;
    end else begin
      unique case (irQ[MSB-1:MSB-2])
        2'd0: idispMod = MOD_W'(irQ[MSB-3:MSB-4]);
        2'd1: idispMod = MOD_W'(4);
        2'd2: idispMod = MOD_W'(5);
        default: begin
          unique case (irQ[MSB-4:MSB-7])
            4'd0:    idispMod = MOD_W'(1);
            4'd1:    idispMod = MOD_W'(0);
            4'd6:    idispMod = MOD_W'(14);
            4'd14:   idispMod = MOD_W'(6);
            default: idispMod = irQ[MSB-4:MSB-7];
          endcase
        end
      endcase
    end
  end

  assign acSrcMod = irQ[MSB] ? shComplMod : tblMod;

  always_comb begin
    nextMod = '0;
    if (strb.loadIr)      nextMod = loadMod;
    else if (strb.idisp)  nextMod = idispMod;
    else if (strb.busOdd) nextMod = MOD_W'(busIn[0]);
    else if (strb.acSrc)  nextMod = acSrcMod;
  end

  // Accumulator substitution into the low register-select bits.
  assign srcAc = irQ[MSB-1:MSB-2] ^ 2'b11;
  assign dstAc = irQ[MSB-3:MSB-4] ^ 2'b11;

  always_comb begin
    rSelOut = rSelIn;
    if (strb.acSrc)      rSelOut[1:0] = srcAc;
    else if (strb.acDst) rSelOut[1:0] = dstAc;
  end

  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIr |=> (irOut == $past(busIn))); // R1

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadIr |=> $stable(irOut)); // R1

  AST_SKIP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIr |=> !skipOut); // R3

  AST_SKIP_SET: assert property (@(posedge clk) disable iff (!rstN)
    (skipSet && !strb.loadIr) |=> skipOut); // R3

  AST_ODD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.busOdd |-> (nextMod[MOD_W-1:1] == '0)); // R6

  AST_RSEL_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    rSelOut[RSEL_W-1:2] == rSelIn[RSEL_W-1:2]); // R8

  AST_IDLE_MOD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |-> (nextMod == '0)); // R9

endmodule

// File: rtl/dispatch_decoder.sv
module dispatch_decoder
  import disp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MOD_W     = 4,
  parameter int RSEL_W    = 5,
  parameter int TBL_IDX_W = 7,
  localparam int TBL_ENTRIES = 1 << TBL_IDX_W,
  parameter logic [TBL_ENTRIES*MOD_W-1:0] AC_TABLE = defaultAcTable()
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        fnCode,
  input  logic [DATA_W-1:0] busIn,
  input  logic [RSEL_W-1:0] rSelIn,
  input  logic              skipSet,
  output logic [MOD_W-1:0]  nextMod,
  output logic [RSEL_W-1:0] rSelOut,
  output logic [DATA_W-1:0] irOut,
  output logic              skipOut
);

  dispStrb_t strb;

  disp_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .fnCode (fnCode),
    .strb   (strb)
  );

  disp_datapath #(
    .DATA_W    (DATA_W),
    .MOD_W     (MOD_W),
    .RSEL_W    (RSEL_W),
    .TBL_IDX_W (TBL_IDX_W),
    .AC_TABLE  (AC_TABLE)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busIn   (busIn),
    .rSelIn  (rSelIn),
    .skipSet (skipSet),
    .nextMod (nextMod),
    .rSelOut (rSelOut),
    .irOut   (irOut),
    .skipOut (skipOut)
  );

endmodule

// File: tb/tb_dispatch_decoder.sv
module tb_dispatch_decoder;

  localparam int CLK_PERIOD = 10;

  function automatic logic [511:0] benchTable();
    logic [511:0] t;
    for (int i = 0; i < 128; i++) t[i*4 +: 4] = 4'((i * 7 + 1) % 16);
    return t;
  endfunction

  localparam logic [511:0] TB_TABLE = benchTable();

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  fnCode = 3'd0;
  logic [15:0] busIn = 16'h0;
  logic [4:0]  rSelIn = 5'h0;
  logic        skipSet = 1'b0;
  logic [3:0]  nextMod;
  logic [4:0]  rSelOut;
  logic [15:0] irOut;
  logic        skipOut;

  int nTests = 0;
  int nFail  = 0;

  dispatch_decoder #(.AC_TABLE(TB_TABLE)) dut (
    .clk(clk), .rstN(rstN), .fnCode(fnCode), .busIn(busIn),
    .rSelIn(rSelIn), .skipSet(skipSet), .nextMod(nextMod),
    .rSelOut(rSelOut), .irOut(irOut), .skipOut(skipOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference models written from the requirements.
  function automatic logic [3:0] modelIdisp(logic [15:0] ir);
    if (ir[15]) return 4'(3 - int'(ir[7:6]));
    if (ir[14:13] == 2'd0) return {2'b00, ir[12:11]};
    if (ir[14:13] == 2'd1) return 4'd4;
    if (ir[14:13] == 2'd2) return 4'd5;
    case (ir[11:8])
      4'd0:  return 4'd1;
      4'd1:  return 4'd0;
      4'd6:  return 4'd14;
      4'd14: return 4'd6;
      default: return ir[11:8];
    endcase
  endfunction

  function automatic logic [3:0] modelAcSrc(logic [15:0] ir);
    if (ir[15]) return 4'(3 - int'(ir[7:6]));
    return TB_TABLE[int'(ir[14:8])*4 +: 4];
  endfunction

  // Drive at negedge, settle, then the edge captures.
  task automatic loadIr(logic [15:0] v);
    @(negedge clk);
    fnCode = 3'd1; busIn = v;
    @(negedge clk);
    fnCode = 3'd0;
  endtask

  task automatic testReset();
    #1;
    check("R10 ir reset", irOut, 16'h0);
    check("R10 skip reset", {15'b0, skipOut}, 16'h0);
    check("R9 idle mod", {12'b0, nextMod}, 16'h0);
  endtask

  task automatic testLoad();
    loadIr(16'h1234);
    @(negedge clk);
    fnCode = 3'd1; busIn = 16'h8500;
    #1;
    check("R2 load mod 8500", {12'b0, nextMod}, 16'h000D);
    check("R1 old ir held in load cycle", irOut, 16'h1234);
    @(negedge clk);
    fnCode = 3'd0; busIn = 16'h0300;
    #1;
    check("R1 ir captured", irOut, 16'h8500);
    fnCode = 3'd1;
    #1;
    check("R2 load mod 0300", {12'b0, nextMod}, 16'h0003);
    @(negedge clk);
    fnCode = 3'd0; busIn = 16'hFFFF;
    @(negedge clk);
    check("R1 ir holds", irOut, 16'h0300);
  endtask

  task automatic testSkip();
    @(negedge clk); skipSet = 1'b1;
    @(negedge clk); skipSet = 1'b0;
    check("R3 skip set", {15'b0, skipOut}, 16'h1);
    loadIr(16'h0000);
    check("R3 load clears skip", {15'b0, skipOut}, 16'h0);
    @(negedge clk); skipSet = 1'b1;
    @(negedge clk);
    fnCode = 3'd1; busIn = 16'h0042;
    @(negedge clk);
    fnCode = 3'd0; skipSet = 1'b0;
    check("R3 clear wins over set", {15'b0, skipOut}, 16'h0);
  endtask

  task automatic testIdisp();
    logic [15:0] pats [13] = '{16'h8080, 16'h80C0, 16'h1800, 16'h0800,
                               16'h2000, 16'h4000, 16'h6000, 16'h6100,
                               16'h6600, 16'h6E00, 16'h6500, 16'h7F00, 16'h6200};
    for (int i = 0; i < 13; i++) begin
      loadIr(pats[i]);
      fnCode = 3'd2; #1;
      check(pats[i][15] || pats[i][14:13] != 2'd3 ? "R4 idisp" : "R5 idisp nibble",
            {12'b0, nextMod}, {12'b0, modelIdisp(pats[i])});
      fnCode = 3'd0;
    end
  endtask

  task automatic testBusOdd();
    @(negedge clk);
    fnCode = 3'd3; busIn = 16'hFFFF; #1;
    check("R6 odd bus 1", {12'b0, nextMod}, 16'h1);
    busIn = 16'hFFFE; #1;
    check("R6 odd bus 0", {12'b0, nextMod}, 16'h0);
    fnCode = 3'd0;
  endtask

  task automatic testAcSrc();
    logic [15:0] pats [5] = '{16'h8040, 16'h3500, 16'h7F00, 16'h0000, 16'h4A00};
    for (int i = 0; i < 5; i++) begin
      loadIr(pats[i]);
      fnCode = 3'd4; #1;
      check("R7 acsrc", {12'b0, nextMod}, {12'b0, modelAcSrc(pats[i])});
      fnCode = 3'd0;
    end
  endtask

  task automatic testRsel();
    loadIr(16'h4800);
    rSelIn = 5'b10111;
    fnCode = 3'd4; #1;
    check("R8 rsel src", {11'b0, rSelOut}, 16'h15);
    fnCode = 3'd5; #1;
    check("R8 rsel dst", {11'b0, rSelOut}, 16'h16);
    check("R9 dst mod zero", {12'b0, nextMod}, 16'h0);
    fnCode = 3'd6; #1;
    check("R8 rsel dns", {11'b0, rSelOut}, 16'h16);
    check("R9 dns mod zero", {12'b0, nextMod}, 16'h0);
    fnCode = 3'd2; #1;
    check("R8 rsel pass", {11'b0, rSelOut}, 16'h17);
    fnCode = 3'd7; #1;
    check("R9 spare mod zero", {12'b0, nextMod}, 16'h0);
    fnCode = 3'd0; #1;
    check("R9 idle rsel pass", {11'b0, rSelOut}, 16'h17);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLoad();
    testSkip();
    testIdisp();
    testBusOdd();
    testAcSrc();
    testRsel();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule